// File: doc/BRIEF.md
# Serial Flash Read-Command Slave

This block is the device-side serial front end of a page-organised flash that keeps one page-sized SRAM buffer next to its main array. A host selects the device by pulling chip select low and clocks in an 8-bit opcode, a 24-bit address field and a number of wait bits, most significant bit first. Two opcodes are served: a direct read of a main-array page and a read of the SRAM buffer. After the wait bits, the block streams bytes on the serial output, MSB first. It keeps a byte pointer that wraps inside the page (or the buffer) at 264 bytes instead of advancing into the next page.

The serial pins are oversampled in the system clock domain, so the whole block runs on one clock. The SCK high and low phases must each last several system clocks. Both storage arrays are synthesizable memories inside the block. A write-only fill port stands in for the program path, which lies outside this block. Chip select going high ends any command at once and releases the output.

Top module: `flash_read_slave`

## Requirements
- R1: While reset is applied, and at any time chip select is high, the serial output enable `spi_so_oe` is 0.
- R2: Opcode 0x52, sampled on SCK rising edges MSB first, starts a page read. In the following 24-bit field, bits 23..18 are ignored, bits 17..9 select the page and bits 8..0 give the start byte. 32 wait bits follow, whatever their value, and then page bytes are sent MSB first.
- R3: Opcode 0x54 starts a buffer read. In the 24-bit field, bits 23..9 are ignored and bits 8..0 give the start byte. 8 wait bits of any value follow, and then buffer bytes are sent MSB first.
- R4: The output is driven only in the data phase. `spi_so_oe` is still 0 at the end of the last wait bit and becomes 1 after the next SCK falling edge. `spi_so` changes only after SCK falling edges and holds steady through each SCK high phase.
- R5: A page read that sends byte 263 continues with byte 0 of the same page.
- R6: A buffer read that sends byte 263 continues with buffer byte 0.
- R7: A start byte of 264 to 511 is taken modulo 264 when it is loaded.
- R8: A page read leaves the buffer contents unchanged.
- R9: Chip select rising in the data phase drops `spi_so_oe` in the same instant, without waiting for a clock edge. The next command then decodes normally.
- R10: Any opcode other than 0x52 and 0x54 keeps `spi_so_oe` at 0 for every following bit until chip select rises. The next command then decodes normally.
- R11: Commands work both with SCK idling low (mode 0) and with SCK idling high (mode 3).
- R12: With `fill_en` high, `fill_data` is written on a clock edge. It goes to buffer byte `fill_byte` when `fill_to_buf` is 1, and to main page `fill_page` (taken modulo the page count) at byte `fill_byte` when `fill_to_buf` is 0. A later read of that location returns the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the serial pins are oversampled with it |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_si | input | 1 | Serial data from the host |
| spi_so | output | 1 | Serial data to the host |
| spi_so_oe | output | 1 | Output enable for the SO pad; 0 means high impedance |
| fill_en | input | 1 | Write strobe of the fill port |
| fill_to_buf | input | 1 | 1 writes the buffer, 0 writes the main array |
| fill_page | input | 9 | Main-array page for a fill write |
| fill_byte | input | 9 | Byte index for a fill write |
| fill_data | input | 8 | Byte written by the fill port |

## Verification
The assertions assume that SCK, chip select and SI change no faster than the synchronisers can follow. Each SCK phase must last at least four system clocks, SI must be settled before each rising edge, and chip select may only move while SCK sits at its idle level. The stimulus meets these assumptions. Every SCK half period is eight system clocks, SI changes together with the SCK falling edge, and every edge is placed on a falling edge of the system clock so that no sample happens at the instant a pin moves. Chip select is raised only after SCK has returned to idle, including in the abort case.

// File: rtl/flash_rd_pkg.sv
`timescale 1ns/1ps
// Shared constants and the command-sequencer state type for the serial
// flash read slave. Assumes 8-bit opcodes and byte-wide data.
package flash_rd_pkg;
    localparam int          PAGE_BYTES      = 264;
    localparam int          OPC_BITS        = 8;
    localparam int          ADDR_FIELD_BITS = 24;
    localparam int          PAGE_WAIT_BITS  = 32;
    localparam int          BUF_WAIT_BITS   = 8;
    localparam logic [7:0]  OPC_PAGE_READ   = 8'h52;
    localparam logic [7:0]  OPC_BUF_READ    = 8'h54;

    typedef enum logic [2:0] {
        RS_OPCODE,   // collecting the opcode
        RS_ADDR,     // collecting the 24-bit address field
        RS_WAIT,     // counting wait bits
        RS_DATA,     // streaming bytes
        RS_DROP      // unknown opcode: ignore until deselect
    } rd_state_t;
endpackage

// File: rtl/spi_pin_sync.sv
`timescale 1ns/1ps
// Brings SCK, chip select and SI into the system clock domain and turns
// SCK transitions into one-cycle pulses. Assumes each SCK phase lasts more
// than STAGES+1 system clocks. All three pins use the same delay, so their
// order is kept.
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic si,
    output logic sck_rise,
    output logic sck_fall,
    output logic sel,
    output logic si_s
);
    logic [STAGES:0]   sck_p;
    logic [STAGES-1:0] cs_p;
    logic [STAGES-1:0] si_p;

    // Shift each pin through its synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_p <= '0;
            cs_p  <= '1;
            si_p  <= '0;
        end else begin
            sck_p <= {sck_p[STAGES-1:0], sck};
            cs_p  <= {cs_p[STAGES-2:0], cs_n};
            si_p  <= {si_p[STAGES-2:0], si};
        end
    end

    // Edge pulses compare the newest settled sample with the one before.
    always_comb begin
        sck_rise = sck_p[STAGES-1] && !sck_p[STAGES];
        sck_fall = !sck_p[STAGES-1] && sck_p[STAGES];
        sel      = !cs_p[STAGES-1];
        si_s     = si_p[STAGES-1];
    end

    initial begin
        if (STAGES < 2) $error("spi_pin_sync needs at least two stages");
    end
endmodule

// File: rtl/wrap_ptr.sv
`timescale 1ns/1ps
// Byte pointer that wraps at DEPTH. A load reduces its value modulo DEPTH
// with one subtraction, which assumes the load value is below 2*DEPTH.
module wrap_ptr #(
    parameter int DEPTH = 264,
    parameter int AW    = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    output logic [AW-1:0] ptr
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [AW-1:0] SPAN = AW'(DEPTH);

    // Load with modulo reduction, otherwise step and wrap at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= (load_val >= SPAN) ? load_val - SPAN : load_val;
        end else if (step) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end

    initial begin
        if ((2 * DEPTH) < (1 << AW)) $error("wrap_ptr: one subtraction cannot reduce every load value");
    end

    // R7: the pointer never leaves the page.
    p_ptr_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ptr < SPAN);

    // R5 / R6: stepping past the last byte returns to byte 0.
    p_ptr_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && ptr == LAST) |=> (ptr == '0));
endmodule

// File: rtl/page_store.sv
`timescale 1ns/1ps
// Main array of PAGES pages plus one page-sized buffer, both synchronous
// RAMs with a single registered read port. A write-only fill port loads
// either one. Page numbers wrap modulo PAGES. Byte indexes at or above
// PAGE_BYTES are dropped on write.
module page_store #(
    parameter int PAGES      = 8,
    parameter int PAGE_BYTES = 264,
    parameter int PAGE_AW    = 9,
    parameter int BYTE_AW    = 9,
    parameter int DW         = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fill_en,
    input  logic               fill_to_buf,
    input  logic [PAGE_AW-1:0] fill_page,
    input  logic [BYTE_AW-1:0] fill_byte,
    input  logic [DW-1:0]      fill_data,
    input  logic               rd_buf,
    input  logic [PAGE_AW-1:0] rd_page,
    input  logic [BYTE_AW-1:0] rd_byte,
    output logic [DW-1:0]      rd_data
);
    localparam int MAIN_DEPTH = PAGES * PAGE_BYTES;
    localparam int MA_W       = $clog2(MAIN_DEPTH);

    logic [DW-1:0] main_mem [MAIN_DEPTH];
    logic [DW-1:0] buf_mem  [PAGE_BYTES];
    logic [MA_W-1:0] wr_addr;
    logic [MA_W-1:0] rd_addr;
    logic            byte_ok;

    function automatic logic [MA_W-1:0] flat_addr(input logic [PAGE_AW-1:0] pg,
                                                  input logic [BYTE_AW-1:0] by);
        return MA_W'((int'(pg) % PAGES) * PAGE_BYTES + int'(by));
    endfunction

    // Address arithmetic for both ports.
    always_comb begin
        wr_addr = flat_addr(fill_page, fill_byte);
        rd_addr = flat_addr(rd_page, rd_byte);
        byte_ok = int'(fill_byte) < PAGE_BYTES;
    end

    // Fill writes into the main array.
    always_ff @(posedge clk) begin
        if (fill_en && !fill_to_buf && byte_ok) main_mem[wr_addr] <= fill_data;
    end

    // Fill writes into the buffer; nothing else writes it.
    always_ff @(posedge clk) begin
        if (fill_en && fill_to_buf && byte_ok) buf_mem[fill_byte] <= fill_data;
    end

    // Registered read from the selected store.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= rd_buf ? buf_mem[rd_byte] : main_mem[rd_addr];
    end

    initial begin
        if (PAGES < 1) $error("page_store needs at least one page");
    end
endmodule

// File: rtl/rd_cmd_seq.sv
`timescale 1ns/1ps
// Command sequencer. It collects the opcode and the 24-bit address field
// on SCK rising pulses and counts the wait bits for the decoded command.
// In the data phase it presents one bit per SCK falling pulse, MSB first.
// It assumes rd_data follows the pointer within two clocks, well inside
// one SCK phase.
module rd_cmd_seq
    import flash_rd_pkg::*;
#(
    parameter int OP_BITS    = OPC_BITS,
    parameter int FIELD_BITS = ADDR_FIELD_BITS,
    parameter int PG_WAIT    = PAGE_WAIT_BITS,
    parameter int BF_WAIT    = BUF_WAIT_BITS,
    parameter int PAGE_AW    = 9,
    parameter int BYTE_AW    = 9,
    parameter int DW         = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sck_rise,
    input  logic               sck_fall,
    input  logic               sel,
    input  logic               si_s,
    input  logic [DW-1:0]      rd_data,
    output logic               ptr_load,
    output logic [BYTE_AW-1:0] ptr_load_val,
    output logic               ptr_step,
    output logic               rd_buf,
    output logic [PAGE_AW-1:0] rd_page,
    output logic               so_bit,
    output logic               oe_q
);
    localparam int SH_W    = PAGE_AW + BYTE_AW;
    localparam int MAX_A   = (FIELD_BITS > OP_BITS) ? FIELD_BITS : OP_BITS;
    localparam int MAX_B   = (PG_WAIT > BF_WAIT) ? PG_WAIT : BF_WAIT;
    localparam int MAX_CNT = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W   = $clog2(MAX_CNT + 1);
    localparam int BIT_W   = $clog2(DW);
    localparam logic [CNT_W-1:0] OP_LAST    = CNT_W'(OP_BITS - 1);
    localparam logic [CNT_W-1:0] FIELD_LAST = CNT_W'(FIELD_BITS - 1);
    localparam logic [CNT_W-1:0] PG_LAST    = CNT_W'(PG_WAIT - 1);
    localparam logic [CNT_W-1:0] BF_LAST    = CNT_W'(BF_WAIT - 1);

    rd_state_t          state;
    logic [CNT_W-1:0]   bit_cnt;
    logic [SH_W-2:0]    shreg;
    logic [SH_W-1:0]    shift_in;
    logic [OP_BITS-1:0] opc;
    logic               is_buf;
    logic [PAGE_AW-1:0] page_q;
    logic [BIT_W-1:0]   bit_idx;
    logic               so_q;
    logic [CNT_W-1:0]   wait_last;

    // Incoming word with the current SI bit appended.
    always_comb begin
        shift_in  = {shreg, si_s};
        opc       = shift_in[OP_BITS-1:0];
        wait_last = is_buf ? BF_LAST : PG_LAST;
    end

    // Pointer control: load at the end of the field, step after each byte.
    always_comb begin
        ptr_load     = sel && sck_rise && (state == RS_ADDR) && (bit_cnt == FIELD_LAST);
        ptr_load_val = shift_in[BYTE_AW-1:0];
        ptr_step     = sel && sck_fall && (state == RS_DATA) && (bit_idx == '0);
        rd_buf       = is_buf;
        rd_page      = page_q;
        so_bit       = so_q;
    end

    // Command state machine and output shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= RS_OPCODE;
            bit_cnt <= '0;
            shreg   <= '0;
            is_buf  <= 1'b0;
            page_q  <= '0;
            bit_idx <= BIT_W'(DW - 1);
            so_q    <= 1'b0;
            oe_q    <= 1'b0;
        end else if (!sel) begin
            state   <= RS_OPCODE;
            bit_cnt <= '0;
            bit_idx <= BIT_W'(DW - 1);
            so_q    <= 1'b0;
            oe_q    <= 1'b0;
        end else begin
            if (sck_rise) begin
                unique case (state)
                    RS_OPCODE: begin
                        shreg <= shift_in[SH_W-2:0];
                        if (bit_cnt == OP_LAST) begin
                            bit_cnt <= '0;
                            if (opc == OPC_PAGE_READ) begin
                                is_buf <= 1'b0;
                                state  <= RS_ADDR;
                            end else if (opc == OPC_BUF_READ) begin
                                is_buf <= 1'b1;
                                state  <= RS_ADDR;
                            end else begin
                                state  <= RS_DROP;
                            end
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    RS_ADDR: begin
                        shreg <= shift_in[SH_W-2:0];
                        if (bit_cnt == FIELD_LAST) begin
                            bit_cnt <= '0;
                            page_q  <= shift_in[SH_W-1:BYTE_AW];
                            state   <= RS_WAIT;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    RS_WAIT: begin
                        if (bit_cnt == wait_last) begin
                            bit_cnt <= '0;
                            bit_idx <= BIT_W'(DW - 1);
                            state   <= RS_DATA;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
            if (sck_fall && state == RS_DATA) begin
                so_q    <= rd_data[bit_idx];
                oe_q    <= 1'b1;
                bit_idx <= bit_idx - 1'b1;
            end
        end
    end

    initial begin
        if (SH_W - 1 < OP_BITS) $error("rd_cmd_seq: shift register too short for the opcode");
        if (FIELD_BITS < SH_W) $error("rd_cmd_seq: address field shorter than page plus byte");
    end

    // R1: deselect returns the output to high impedance.
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> !oe_q);

    // R4: the output is only enabled while streaming data.
    p_oe_only_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        oe_q |-> (state == RS_DATA));

    // R4: the enable turns on only following a falling SCK pulse.
    p_oe_after_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_q) |-> $past(sck_fall));

    // R4: the data bit changes only following a falling SCK pulse.
    p_so_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && $past(sel) && !$past(sck_fall)) |-> $stable(so_q));

    // R10: a dropped command never drives the pin.
    p_drop_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RS_DROP) |-> !oe_q);

    // R2 / R3: the wait counter stays below the decoded wait length.
    p_wait_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RS_WAIT) |-> (bit_cnt <= wait_last));
endmodule

// File: rtl/flash_read_slave.sv
`timescale 1ns/1ps
// Top of the serial flash read slave. It oversamples the serial pins,
// sequences the page-read and buffer-read commands, and serves data from
// the page store through a wrapping byte pointer. Chip select gates the
// output enable without waiting for a clock edge, so deselect releases
// SO at once.
module flash_read_slave
    import flash_rd_pkg::*;
#(
    parameter int MAIN_PAGES  = 8,
    parameter int PAGE_AW     = 9,
    parameter int BYTE_AW     = 9,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               spi_sck,
    input  logic               spi_cs_n,
    input  logic               spi_si,
    output logic               spi_so,
    output logic               spi_so_oe,
    input  logic               fill_en,
    input  logic               fill_to_buf,
    input  logic [PAGE_AW-1:0] fill_page,
    input  logic [BYTE_AW-1:0] fill_byte,
    input  logic [DW-1:0]      fill_data
);
    logic               sck_rise, sck_fall, sel, si_s;
    logic               ptr_load, ptr_step, rd_buf, oe_q, so_bit;
    logic [BYTE_AW-1:0] ptr_load_val, ptr;
    logic [PAGE_AW-1:0] rd_page;
    logic [DW-1:0]      rd_data;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n), .si(spi_si),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .sel(sel), .si_s(si_s)
    );

    rd_cmd_seq #(
        .PAGE_AW(PAGE_AW), .BYTE_AW(BYTE_AW), .DW(DW)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .sck_fall(sck_fall),
        .sel(sel), .si_s(si_s), .rd_data(rd_data), .ptr_load(ptr_load),
        .ptr_load_val(ptr_load_val), .ptr_step(ptr_step), .rd_buf(rd_buf),
        .rd_page(rd_page), .so_bit(so_bit), .oe_q(oe_q)
    );

    wrap_ptr #(.DEPTH(PAGE_BYTES), .AW(BYTE_AW)) u_ptr (
        .clk(clk), .rst_n(rst_n), .load(ptr_load), .load_val(ptr_load_val),
        .step(ptr_step), .ptr(ptr)
    );

    page_store #(
        .PAGES(MAIN_PAGES), .PAGE_BYTES(PAGE_BYTES), .PAGE_AW(PAGE_AW),
        .BYTE_AW(BYTE_AW), .DW(DW)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .fill_en(fill_en), .fill_to_buf(fill_to_buf),
        .fill_page(fill_page), .fill_byte(fill_byte), .fill_data(fill_data),
        .rd_buf(rd_buf), .rd_page(rd_page), .rd_byte(ptr), .rd_data(rd_data)
    );

    // Pin outputs; the raw chip select releases the pad at once.
    always_comb begin
        spi_so    = so_bit;
        spi_so_oe = oe_q && !spi_cs_n;
    end
endmodule

// File: tb/sim_flash_read_slave.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver task pushes expected bytes and a monitor
// on SCK rising edges assembles SO bits and compares them.
module sim_flash_read_slave;
    localparam int NPG  = 8;
    localparam int PB   = 264;
    localparam int HALF = 64;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       spi_sck = 1'b0, spi_cs_n = 1'b1, spi_si = 1'b0;
    logic       spi_so, spi_so_oe;
    logic       fill_en = 1'b0, fill_to_buf = 1'b0;
    logic [8:0] fill_page = '0, fill_byte = '0;
    logic [7:0] fill_data = '0;

    flash_read_slave #(.MAIN_PAGES(NPG)) u0 (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_si(spi_si), .spi_so(spi_so), .spi_so_oe(spi_so_oe),
        .fill_en(fill_en), .fill_to_buf(fill_to_buf), .fill_page(fill_page),
        .fill_byte(fill_byte), .fill_data(fill_data)
    );

    always #4 clk = ~clk;

    int         n_chk = 0, n_fail = 0;
    logic [7:0] m_main [NPG][PB];
    logic [7:0] m_buf  [PB];
    logic [7:0] exp_q  [$];
    string      cur_req = "R1";
    bit         mon_on = 0, ign_chk = 0, have_so = 0;
    logic [7:0] mon_sh = '0, mon_exp;
    int         mon_n = 0;
    logic       last_so = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Monitor: collect SO bits at SCK rise and score whole bytes.
    always @(posedge spi_sck) begin
        if (mon_on) begin
            chk(spi_so_oe === 1'b1, cur_req, "SO enable in data phase", int'(spi_so_oe), 1);
            mon_sh  = {mon_sh[6:0], spi_so};
            last_so = spi_so;
            have_so = 1;
            mon_n++;
            if (mon_n == 8) begin
                mon_n = 0;
                if (exp_q.size() == 0) begin
                    chk(0, cur_req, "byte with nothing expected", int'(mon_sh), 0);
                end else begin
                    mon_exp = exp_q.pop_front();
                    chk(mon_sh === mon_exp, cur_req, "data byte", int'(mon_sh), int'(mon_exp));
                end
            end
        end
        if (ign_chk) chk(spi_so_oe === 1'b0, "R10", "SO enable after unknown opcode", int'(spi_so_oe), 0);
    end

    // R4: SO must hold through the high phase up to the falling edge.
    always @(negedge spi_sck) begin
        if (mon_on && have_so)
            chk(spi_so === last_so, "R4", "SO held over SCK high", int'(spi_so), int'(last_so));
    end

    task automatic send_bit(input logic b);
        spi_sck = 1'b0;
        spi_si  = b;
        #HALF;
        spi_sck = 1'b1;
        #HALF;
    endtask

    // Driver: one command; expected bytes come from the bench's own model.
    task automatic spi_cmd(input bit m3, input logic [7:0] op, input logic [23:0] hdr,
                           input int nwait, input int nbytes, input int abort_bits,
                           input string req);
        bit valid, isb;
        int pg, st;
        @(negedge clk);
        cur_req = req; mon_n = 0; have_so = 0;
        valid = (op == 8'h52) || (op == 8'h54);
        isb   = (op == 8'h54);
        spi_sck = m3;
        #HALF; spi_cs_n = 1'b0; #HALF;
        for (int i = 7; i >= 0; i--) send_bit(op[i]);
        if (!valid) ign_chk = 1;
        for (int i = 23; i >= 0; i--) send_bit(hdr[i]);
        for (int i = 0; i < nwait; i++) send_bit(1'b1);
        if (valid) begin
            chk(spi_so_oe === 1'b0, "R4", "SO enable before first data fall", int'(spi_so_oe), 0);
            pg = int'(hdr[17:9]) % NPG;
            st = int'(hdr[8:0]);
            if (st >= PB) st -= PB;
            for (int k = 0; k < nbytes; k++)
                exp_q.push_back(isb ? m_buf[(st + k) % PB] : m_main[pg][(st + k) % PB]);
            mon_on = 1;
            for (int k = 0; k < nbytes * 8 + abort_bits; k++) send_bit(1'b0);
            if (abort_bits > 0)
                chk(spi_so_oe === 1'b1, req, "SO enable before abort", int'(spi_so_oe), 1);
        end
        mon_on = 0; ign_chk = 0;
        if (!m3) spi_sck = 1'b0;
        #HALF;
        spi_cs_n = 1'b1;
        #1;
        chk(spi_so_oe === 1'b0, "R9", "SO enable right after deselect", int'(spi_so_oe), 0);
        chk(exp_q.size() == 0, req, "expected bytes left", exp_q.size(), 0);
        exp_q.delete();
        #HALF;
        @(negedge clk);
    endtask

    // R12: fill-port write, mirrored into the bench model.
    task automatic fill_one(input bit tb, input int pg, input int by, input logic [7:0] d);
        @(negedge clk);
        fill_en = 1'b1; fill_to_buf = tb; fill_page = 9'(pg); fill_byte = 9'(by); fill_data = d;
        if (tb) m_buf[by] = d; else m_main[pg % NPG][by] = d;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        n_fail++;
        $display("FAIL watchdog (R1..R12 run): actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (10) @(negedge clk);
        chk(spi_so_oe === 1'b0, "R1", "SO enable during reset", int'(spi_so_oe), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(spi_so_oe === 1'b0, "R1", "SO enable after reset, deselected", int'(spi_so_oe), 0);

        // Load both stores with computed patterns through the fill port (R12).
        for (int p = 0; p < NPG; p++)
            for (int b = 0; b < PB; b++) begin
                @(negedge clk);
                fill_en = 1'b1; fill_to_buf = 1'b0; fill_page = 9'(p); fill_byte = 9'(b);
                fill_data = 8'((p * 37 + b * 5 + 3) & 255);
                m_main[p][b] = fill_data;
            end
        for (int b = 0; b < PB; b++) begin
            @(negedge clk);
            fill_en = 1'b1; fill_to_buf = 1'b1; fill_page = '0; fill_byte = 9'(b);
            fill_data = 8'((b * 11 + 90) & 255);
            m_buf[b] = fill_data;
        end
        @(negedge clk);
        fill_en = 1'b0;

        // R2: page read, reserved bits set to ones, mode 0.
        spi_cmd(0, 8'h52, {6'h3F, 9'd3, 9'd10}, 32, 6, 0, "R2");
        // R3: buffer read with all ignored and wait bits at one.
        spi_cmd(0, 8'h54, {15'h7FFF, 9'd100}, 8, 5, 0, "R3");
        // R5: page wrap from byte 263 to 0 of the same page.
        spi_cmd(0, 8'h52, {6'h00, 9'd5, 9'd261}, 32, 6, 0, "R5");
        // R6: buffer wrap.
        spi_cmd(0, 8'h54, {15'h0000, 9'd262}, 8, 4, 0, "R6");
        // R7: start bytes above the page are reduced modulo 264.
        spi_cmd(0, 8'h52, {6'h00, 9'd2, 9'd300}, 32, 3, 0, "R7");
        spi_cmd(0, 8'h52, {6'h00, 9'd7, 9'd511}, 32, 2, 0, "R7");
        // R9: abort three bits into a page read.
        spi_cmd(0, 8'h52, {6'h00, 9'd1, 9'd0}, 32, 0, 3, "R9");
        // R8: whole buffer still holds its pattern after the page reads.
        spi_cmd(0, 8'h54, {15'h0000, 9'd0}, 8, 266, 0, "R8");
        // R10: unknown opcode followed by many bits, then a normal read.
        spi_cmd(0, 8'hA5, 24'hFFFFFF, 32, 0, 0, "R10");
        spi_cmd(0, 8'h54, {15'h0000, 9'd5}, 8, 2, 0, "R10");
        // R11: SCK idling high.
        spi_cmd(1, 8'h52, {6'h00, 9'd6, 9'd0}, 32, 3, 0, "R11");
        spi_cmd(1, 8'h54, {15'h0000, 9'd263}, 8, 2, 0, "R11");
        // R12: overwrite single bytes and read them back.
        fill_one(1'b1, 0, 7, 8'hC3);
        fill_one(1'b0, 4, 0, 8'h3C);
        spi_cmd(0, 8'h54, {15'h0000, 9'd6}, 8, 3, 0, "R12");
        spi_cmd(0, 8'h52, {6'h00, 9'd4, 9'd263}, 32, 2, 0, "R12");

        summary();
        $finish;
    end
endmodule